// File: doc/BRIEF.md
# AXI ID Port-Channel Transaction Filter

This block sits beside a memory controller's performance counters and decides, on each AXI address handshake, which of the filtered event counters should count that transaction. Each counter is tagged with an event code. Code 0x41 makes the counter watch the read address channel, and code 0x42 makes it watch the write address channel. A transaction is accepted when its ID agrees with a programmed compare ID on every bit the mask marks as significant. In the per-counter variant, the transaction's port number and sub-channel bit must also match the fields programmed for that counter.

For each accepted transaction the block emits a one-cycle qualify pulse for the counter, together with the transaction's size in bytes. It also keeps a running byte total for each counter, which can be read back and cleared through a small register port. Counter index n (1 to NCNT) maps to bit n-1 of every per-counter vector.

A build parameter selects between two variants. In the first, every counter has its own ID/mask register and port-mux register. In the second, all counters share a single ID/mask register and the port and channel checks are skipped.

Top module: `axid_txn_qualifier`

## Requirements
- R1: After a synchronous reset, every qualify pulse is 0, every byte output is 0, and every register and byte total reads back 0.
- R2: A filter word holds the compare ID in bits 15:0 and the stored mask in bits 31:16. A transaction ID matches when it equals the compare ID on every bit where the stored mask is 1. Bits where the stored mask is 0 are ignored.
- R3: A counter whose event code is neither 0x41 nor 0x42 never asserts its qualify pulse.
- R4: In the per-counter variant, event 0x41 requires the read port to equal mux bits 2:0 and the read sub-channel to equal the inverse of mux bit 3. Event 0x42 requires the write port to equal mux bits 10:8 and the write sub-channel to equal the inverse of mux bit 11.
- R5: Qualification needs a completed address handshake (valid and ready both high) on the selected channel. Valid alone qualifies nothing.
- R6: The qualify pulse and the byte value appear one clock after the handshake edge. The byte value is (len+1)·2^size. It is 0 in every cycle without a pulse.
- R7: Each pulse adds its byte value to that counter's 32-bit total. Total n reads at address 0x30+4n. Read data appears one clock after the read strobe.
- R8: A write of any data to address 0x30+4n clears total n.
- R9: In the per-counter variant, counter n's filter word is at 0x54+16(n-1) and its mux word is at 0x50+16(n-1). Both are writable and read back what was written.
- R10: In the shared variant, every counter uses the word at 0x30 as its filter word and ignores port and sub-channel. Reads of the per-counter addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rd_data | output | 32 | Registered read data |
| ctr_event | input | NCNT*8 | Event code per counter, counter n at bits 8n-1:8(n-1) |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read transaction ID |
| ar_len | input | LEN_W | Read burst length minus one |
| ar_size | input | SIZE_W | Read beat size, log2 bytes |
| ar_port | input | 3 | Read source port number |
| ar_chan | input | 1 | Read sub-channel bit |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write transaction ID |
| aw_len | input | LEN_W | Write burst length minus one |
| aw_size | input | SIZE_W | Write beat size, log2 bytes |
| aw_port | input | 3 | Write source port number |
| aw_chan | input | 1 | Write sub-channel bit |
| qual_pulse | output | NCNT | One-cycle qualify pulse per counter |
| qual_bytes | output | NCNT*BYTE_W | Byte size of the qualified transaction per counter |

## Verification
Several properties are checked on every cycle. A counter without a filtered event code stays silent. Every pulse follows a completed handshake on the channel its event code picks. The byte value is nonzero exactly when the pulse is high, and reset leaves the outputs quiet. What only the scenarios can show is whether the right transactions pass: the ID/mask decision, the inverted sub-channel sense, the separate read and write port fields, the exact byte count at the largest burst, the totals and their clear, and the shared variant ignoring port fields. The bench computes all of these from its own model of what it programmed.

// File: rtl/axq_pkg.sv
package axq_pkg;
  localparam logic [7:0] EV_AXI_RD = 8'h41;
  localparam logic [7:0] EV_AXI_WR = 8'h42;

  localparam int OFS_SHARED     = 'h30;
  localparam int OFS_TOTAL_BASE = 'h34;
  localparam int OFS_MUX_BASE   = 'h50;
  localparam int OFS_FILT_BASE  = 'h54;
  localparam int OFS_STRIDE     = 16;
  localparam int TOTAL_STRIDE   = 4;

  localparam int MASK_LSB    = 16;
  localparam int PORT_W      = 3;
  localparam int RD_PORT_LSB = 0;
  localparam int RD_CHAN_BIT = 3;
  localparam int WR_PORT_LSB = 8;
  localparam int WR_CHAN_BIT = 11;
endpackage

// File: rtl/axq_regs.sv
module axq_regs
  import axq_pkg::*;
#(
  parameter int NCNT    = 3,
  parameter int ADDR_W  = 8,
  parameter int ACC_W   = 32,
  parameter bit PER_CTR = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  input  logic [NCNT*ACC_W-1:0] totals,
  output logic [NCNT*32-1:0]    filt_words,
  output logic [NCNT*32-1:0]    mux_words,
  output logic [NCNT-1:0]       clr,
  output logic [31:0]           rd_data
);
  logic [31:0] shared_q;
  logic [31:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) shared_q <= '0;
    else if (wr_en && int'(addr) == OFS_SHARED) shared_q <= wdata;
  end

  for (genvar k = 0; k < NCNT; k++) begin : g_ctr
    localparam int A_MUX  = OFS_MUX_BASE + OFS_STRIDE * k;
    localparam int A_FILT = OFS_FILT_BASE + OFS_STRIDE * k;
    localparam int A_TOT  = OFS_TOTAL_BASE + TOTAL_STRIDE * k;

    assign clr[k] = wr_en && int'(addr) == A_TOT;

    if (PER_CTR) begin : g_own
      logic [31:0] filt_q, mux_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          filt_q <= '0;
          mux_q  <= '0;
        end else if (wr_en) begin
          if (int'(addr) == A_FILT) filt_q <= wdata;
          if (int'(addr) == A_MUX)  mux_q  <= wdata;
        end
      end
      assign filt_words[k*32 +: 32] = filt_q;
      assign mux_words[k*32 +: 32]  = mux_q;
    end else begin : g_shr
      assign filt_words[k*32 +: 32] = shared_q;
      assign mux_words[k*32 +: 32]  = '0;
    end
  end

  always_comb begin
    rd_next = '0;
    if (int'(addr) == OFS_SHARED) rd_next = shared_q;
    for (int k = 0; k < NCNT; k++) begin
      if (int'(addr) == OFS_TOTAL_BASE + TOTAL_STRIDE * k)
        rd_next = 32'(totals[k*ACC_W +: ACC_W]);
      if (PER_CTR && int'(addr) == OFS_FILT_BASE + OFS_STRIDE * k)
        rd_next = filt_words[k*32 +: 32];
      if (PER_CTR && int'(addr) == OFS_MUX_BASE + OFS_STRIDE * k)
        rd_next = mux_words[k*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/axq_match.sv
module axq_match
  import axq_pkg::*;
#(
  parameter int ID_W    = 16,
  parameter int LEN_W   = 8,
  parameter int SIZE_W  = 3,
  parameter int BYTE_W  = 16,
  parameter bit PER_CTR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        ev,
  input  logic [31:0]       filt,
  input  logic [31:0]       mux,
  input  logic              ar_hs,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic [SIZE_W-1:0] ar_size,
  input  logic [PORT_W-1:0] ar_port,
  input  logic              ar_chan,
  input  logic              aw_hs,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic [SIZE_W-1:0] aw_size,
  input  logic [PORT_W-1:0] aw_port,
  input  logic              aw_chan,
  output logic              qual,
  output logic [BYTE_W-1:0] bytes
);
  logic              sel_rd, sel_wr, hs, chan, want_chan;
  logic [ID_W-1:0]   id;
  logic [LEN_W-1:0]  len;
  logic [SIZE_W-1:0] size;
  logic [PORT_W-1:0] port, want_port;
  logic              id_ok, path_ok, hit;
  logic [BYTE_W-1:0] burst_bytes;

  assign sel_rd = (ev == EV_AXI_RD);
  assign sel_wr = (ev == EV_AXI_WR);

  always_comb begin
    if (sel_rd) begin
      hs = ar_hs;  id = ar_id;  len = ar_len;  size = ar_size;
      port = ar_port;  chan = ar_chan;
      want_port = mux[RD_PORT_LSB +: PORT_W];
      want_chan = ~mux[RD_CHAN_BIT];
    end else begin
      hs = aw_hs && sel_wr;  id = aw_id;  len = aw_len;  size = aw_size;
      port = aw_port;  chan = aw_chan;
      want_port = mux[WR_PORT_LSB +: PORT_W];
      want_chan = ~mux[WR_CHAN_BIT];
    end
  end

  assign id_ok       = ((id ^ filt[ID_W-1:0]) & filt[MASK_LSB +: ID_W]) == '0;
  assign path_ok     = !PER_CTR || (port == want_port && chan == want_chan);
  assign hit         = hs && id_ok && path_ok;
  assign burst_bytes = (BYTE_W'(len) + BYTE_W'(1)) << size;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual  <= 1'b0;
      bytes <= '0;
    end else begin
      qual  <= hit;
      bytes <= hit ? burst_bytes : '0;
    end
  end
endmodule

// File: rtl/axq_accum.sv
module axq_accum #(
  parameter int BYTE_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              add_en,
  input  logic [BYTE_W-1:0] add_val,
  output logic [ACC_W-1:0]  total
);
  always_ff @(posedge clk) begin
    if (rst || clr) total <= '0;
    else if (add_en) total <= total + ACC_W'(add_val);
  end
endmodule

// File: rtl/axid_txn_qualifier.sv
module axid_txn_qualifier
  import axq_pkg::*;
#(
  parameter int NCNT    = 3,
  parameter int ADDR_W  = 8,
  parameter int ID_W    = 16,
  parameter int LEN_W   = 8,
  parameter int SIZE_W  = 3,
  parameter int ACC_W   = 32,
  parameter bit PER_CTR = 1'b1,
  localparam int BYTE_W = LEN_W + (1 << SIZE_W)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_wr_en,
  input  logic                   reg_rd_en,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rd_data,
  input  logic [NCNT*8-1:0]      ctr_event,
  input  logic                   ar_valid,
  input  logic                   ar_ready,
  input  logic [ID_W-1:0]        ar_id,
  input  logic [LEN_W-1:0]       ar_len,
  input  logic [SIZE_W-1:0]      ar_size,
  input  logic [2:0]             ar_port,
  input  logic                   ar_chan,
  input  logic                   aw_valid,
  input  logic                   aw_ready,
  input  logic [ID_W-1:0]        aw_id,
  input  logic [LEN_W-1:0]       aw_len,
  input  logic [SIZE_W-1:0]      aw_size,
  input  logic [2:0]             aw_port,
  input  logic                   aw_chan,
  output logic [NCNT-1:0]        qual_pulse,
  output logic [NCNT*BYTE_W-1:0] qual_bytes
);
  logic [NCNT*32-1:0]    filt_words, mux_words;
  logic [NCNT-1:0]       clr;
  logic [NCNT*ACC_W-1:0] totals;
  logic                  ar_hs, aw_hs;

  assign ar_hs = ar_valid && ar_ready;
  assign aw_hs = aw_valid && aw_ready;

  axq_regs #(.NCNT(NCNT), .ADDR_W(ADDR_W), .ACC_W(ACC_W), .PER_CTR(PER_CTR)) i_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
    .wdata(reg_wdata), .totals(totals), .filt_words(filt_words), .mux_words(mux_words),
    .clr(clr), .rd_data(reg_rd_data)
  );

  for (genvar k = 0; k < NCNT; k++) begin : g_ctr
    axq_match #(.ID_W(ID_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .BYTE_W(BYTE_W),
                .PER_CTR(PER_CTR)) i_match (
      .clk(clk), .rst(rst), .ev(ctr_event[k*8 +: 8]),
      .filt(filt_words[k*32 +: 32]), .mux(mux_words[k*32 +: 32]),
      .ar_hs(ar_hs), .ar_id(ar_id), .ar_len(ar_len), .ar_size(ar_size),
      .ar_port(ar_port), .ar_chan(ar_chan),
      .aw_hs(aw_hs), .aw_id(aw_id), .aw_len(aw_len), .aw_size(aw_size),
      .aw_port(aw_port), .aw_chan(aw_chan),
      .qual(qual_pulse[k]), .bytes(qual_bytes[k*BYTE_W +: BYTE_W])
    );

    axq_accum #(.BYTE_W(BYTE_W), .ACC_W(ACC_W)) i_accum (
      .clk(clk), .rst(rst), .clr(clr[k]), .add_en(qual_pulse[k]),
      .add_val(qual_bytes[k*BYTE_W +: BYTE_W]), .total(totals[k*ACC_W +: ACC_W])
    );
  end
endmodule

// File: rtl/axq_checker.sv
module axq_checker #(
  parameter int NCNT   = 3,
  parameter int BYTE_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NCNT*8-1:0]      ctr_event,
  input logic                   ar_valid,
  input logic                   ar_ready,
  input logic                   aw_valid,
  input logic                   aw_ready,
  input logic [NCNT-1:0]        qual_pulse,
  input logic [NCNT*BYTE_W-1:0] qual_bytes
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (qual_pulse == '0 && qual_bytes == '0)); // R1

  for (genvar k = 0; k < NCNT; k++) begin : g_chk
    AST_UNFILTERED_SILENT: assert property (@(posedge clk) disable iff (rst)
      !($past(ctr_event[k*8 +: 8]) == 8'h41 || $past(ctr_event[k*8 +: 8]) == 8'h42)
      |-> !qual_pulse[k]); // R3

    AST_PULSE_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
      qual_pulse[k] |->
        (($past(ctr_event[k*8 +: 8]) == 8'h41 && $past(ar_valid && ar_ready)) ||
         ($past(ctr_event[k*8 +: 8]) == 8'h42 && $past(aw_valid && aw_ready)))); // R5

    AST_BYTES_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !qual_pulse[k] |-> qual_bytes[k*BYTE_W +: BYTE_W] == '0); // R6

    AST_BYTES_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
      qual_pulse[k] |-> qual_bytes[k*BYTE_W +: BYTE_W] != '0); // R6
  end
endmodule

bind axid_txn_qualifier axq_checker #(.NCNT(NCNT), .BYTE_W(BYTE_W)) i_chk (
  .clk(clk), .rst(rst), .ctr_event(ctr_event), .ar_valid(ar_valid), .ar_ready(ar_ready),
  .aw_valid(aw_valid), .aw_ready(aw_ready), .qual_pulse(qual_pulse), .qual_bytes(qual_bytes)
);

// File: tb/test_axid_txn_qualifier.sv
`timescale 1ns/1ps
module test_axid_txn_qualifier;
  localparam int NCNT = 3;
  localparam int BW   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data, rd_data_s;
  logic [7:0] ev_m [NCNT];
  logic [NCNT*8-1:0] ctr_event;
  logic ar_valid = 0, ar_ready = 0, ar_chan = 0;
  logic aw_valid = 0, aw_ready = 0, aw_chan = 0;
  logic [15:0] ar_id = '0, aw_id = '0;
  logic [7:0] ar_len = '0, aw_len = '0;
  logic [2:0] ar_size = '0, aw_size = '0, ar_port = '0, aw_port = '0;
  logic [NCNT-1:0] qual, qual_s;
  logic [NCNT*BW-1:0] qbytes, qbytes_s;

  logic [31:0] fw_m [NCNT];
  logic [31:0] mw_m [NCNT];
  logic [31:0] shared_m;
  longint acc_m [NCNT];
  int exp_ctr[$];
  int exp_bytes[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  assign ctr_event = {ev_m[2], ev_m[1], ev_m[0]};

  always #4 clk = ~clk;

  axid_txn_qualifier i_axid_txn_qualifier (
    .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_rd_en(rd_en), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rd_data(rd_data), .ctr_event(ctr_event),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len),
    .ar_size(ar_size), .ar_port(ar_port), .ar_chan(ar_chan),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len),
    .aw_size(aw_size), .aw_port(aw_port), .aw_chan(aw_chan),
    .qual_pulse(qual), .qual_bytes(qbytes));

  axid_txn_qualifier #(.PER_CTR(1'b0)) i_shared (
    .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_rd_en(rd_en), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rd_data(rd_data_s), .ctr_event(ctr_event),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len),
    .ar_size(ar_size), .ar_port(ar_port), .ar_chan(ar_chan),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len),
    .aw_size(aw_size), .aw_port(aw_port), .aw_chan(aw_chan),
    .qual_pulse(qual_s), .qual_bytes(qbytes_s));

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard for every pulse seen (R6 bytes, R2/R4 hits)
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < NCNT; k++) begin
        if (qual[k]) begin
          if (exp_ctr.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2/R4 unexpected pulse: actual ctr %0d expected none", k + 1);
          end else begin
            check("R6 pulse counter", k + 1, exp_ctr.pop_front() + 1);
            check("R6 byte value", qbytes[k*BW +: BW], exp_bytes.pop_front());
          end
        end
      end
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 8'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d, output logic [31:0] ds);
    @(negedge clk); rd_en = 1; addr = 8'(a);
    @(negedge clk); rd_en = 0; d = rd_data; ds = rd_data_s;
  endtask

  function automatic bit model_hit(int k, bit is_rd, logic [15:0] id, logic [2:0] port,
                                   bit chan, bit per_ctr);
    logic [31:0] w, m;
    w = per_ctr ? fw_m[k] : shared_m;
    m = mw_m[k];
    if (is_rd && ev_m[k] != 8'h41) return 0;
    if (!is_rd && ev_m[k] != 8'h42) return 0;
    if (((id ^ w[15:0]) & w[31:16]) != 16'h0) return 0;
    if (per_ctr) begin
      if (is_rd && !(port == m[2:0] && chan != m[3])) return 0;
      if (!is_rd && !(port == m[10:8] && chan != m[11])) return 0;
    end
    return 1;
  endfunction

  task automatic issue(string req, bit is_rd, logic [15:0] id, logic [2:0] port, bit chan,
                       logic [7:0] len, logic [2:0] size, bit rdy);
    logic [NCNT-1:0] exp_s;
    int nb;
    nb = (int'(len) + 1) << size;
    exp_s = '0;
    @(negedge clk);
    if (is_rd) begin
      ar_valid = 1; ar_ready = rdy; ar_id = id; ar_port = port; ar_chan = chan;
      ar_len = len; ar_size = size;
    end else begin
      aw_valid = 1; aw_ready = rdy; aw_id = id; aw_port = port; aw_chan = chan;
      aw_len = len; aw_size = size;
    end
    for (int k = 0; k < NCNT; k++) begin
      if (rdy && model_hit(k, is_rd, id, port, chan, 1'b1)) begin
        exp_ctr.push_back(k); exp_bytes.push_back(nb); acc_m[k] += nb;
      end
      if (rdy && model_hit(k, is_rd, id, port, chan, 1'b0)) exp_s[k] = 1'b1;
    end
    @(negedge clk);
    ar_valid = 0; ar_ready = 0; aw_valid = 0; aw_ready = 0;
    check({req, " shared-variant pulses (R10)"}, qual_s, exp_s);
    repeat (2) @(negedge clk);
    check({req, " no missing pulse"}, exp_ctr.size(), 0);
  endtask

  task automatic prog(int k, logic [31:0] f, logic [31:0] m);
    wr('h54 + 16 * k, f); fw_m[k] = f;
    wr('h50 + 16 * k, m); mw_m[k] = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ds;
    for (int k = 0; k < NCNT; k++) begin
      ev_m[k] = 8'h00; fw_m[k] = '0; mw_m[k] = '0; acc_m[k] = 0;
    end
    shared_m = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 qual after reset", qual, 0);
    check("R1 bytes after reset", qbytes, 0);
    rd('h54, d, ds); check("R1 filter word 1", d, 0);
    rd('h50, d, ds); check("R1 mux word 1", d, 0);
    rd('h34, d, ds); check("R1 total 1", d, 0);
    rd('h30, d, ds); check("R1 shared word", d, 0);

    // Configuration; R9 readback
    ev_m[0] = 8'h41; ev_m[1] = 8'h42; ev_m[2] = 8'h00;
    prog(0, 32'h00FF_0012, 32'h0000_0002);   // read port 2, sub-channel 1
    prog(1, 32'hFFFF_0ABC, 32'h0000_0D00);   // write port 5, sub-channel 0
    prog(2, 32'h0000_0000, 32'h0000_0000);
    wr('h30, 32'hF000_3000); shared_m = 32'hF000_3000;
    rd('h54, d, ds); check("R9 filter word 1", d, 32'h00FF_0012);
    rd('h60, d, ds); check("R9 mux word 2", d, 32'h0000_0D00);
    rd('h64, d, ds); check("R9 filter word 2", d, 32'hFFFF_0ABC);
    check("R10 shared variant per-counter read", ds, 0);
    rd('h30, d, ds); check("R10 shared word", ds, 32'hF000_3000);

    issue("R2 exact id", 1, 16'h3412, 3'd2, 1, 8'd3, 3'd2, 1);
    issue("R2 masked bit differs", 1, 16'h3413, 3'd2, 1, 8'd0, 3'd0, 1);
    issue("R2 ignored bits differ", 1, 16'hFF12, 3'd2, 1, 8'd0, 3'd0, 1);
    issue("R4 read port mismatch", 1, 16'h3012, 3'd3, 1, 8'd1, 3'd1, 1);
    issue("R4 read sub-channel mismatch", 1, 16'h0012, 3'd2, 0, 8'd1, 3'd1, 1);
    issue("R6 largest write burst", 0, 16'h0ABC, 3'd5, 0, 8'd255, 3'd7, 1);
    issue("R4 write sub-channel mismatch", 0, 16'h0ABC, 3'd5, 1, 8'd0, 3'd0, 1);
    issue("R4 write uses write port field", 0, 16'h0ABC, 3'd2, 0, 8'd0, 3'd0, 1);
    issue("R5 valid without ready", 1, 16'h3412, 3'd2, 1, 8'd0, 3'd0, 0);
    issue("R5 write valid without ready", 0, 16'h0ABC, 3'd5, 0, 8'd0, 3'd0, 0);
    issue("R2 write id mismatch", 0, 16'h0ABD, 3'd5, 0, 8'd0, 3'd0, 1);
    issue("R3 counter 3 without event", 1, 16'h3012, 3'd0, 1, 8'd0, 3'd0, 1);

    // R7 totals
    rd('h34, d, ds); check("R7 total 1", d, acc_m[0]);
    rd('h38, d, ds); check("R7 total 2", d, acc_m[1]);
    rd('h3C, d, ds); check("R7 total 3", d, acc_m[2]);

    // R8 clear one total only
    wr('h34, 32'h1234_5678); acc_m[0] = 0;
    rd('h34, d, ds); check("R8 cleared total 1", d, 0);
    rd('h38, d, ds); check("R8 total 2 untouched", d, acc_m[1]);

    // R3 enabling counter 3 makes it count
    ev_m[2] = 8'h41;
    @(negedge clk);
    issue("R3 counter 3 enabled", 1, 16'h5555, 3'd0, 1, 8'd7, 3'd3, 1);
    rd('h3C, d, ds); check("R7 total 3 after enable", d, acc_m[2]);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule